// File: doc/BRIEF.md
# LIN Status and Interrupt Tracker

This block holds the eight-bit status byte of a LIN controller and drives its interrupt line. A separate protocol engine reports what happens on the bus through single-cycle event strobes. These events are bus activity, sync break seen, identifier received, frame start, frame end, communication error, wakeup sent and wakeup received. Software adds three control strobes: stop, interrupt acknowledge and error acknowledge. Each status bit follows its own set and clear rule. Whenever a set and a clear reach the same bit in one cycle, the set wins.

A mode input selects master or slave operation. Three bits are meaningful only in slave mode: the idle timeout, the abort flag and the identifier-request flag. In master mode they read as zero. The idle timeout counts clock cycles since the last bus activity, up to a parameterised limit. The status byte is visible on a direct output, and also through a small read port at a fixed indirect address.

Top module: `lin_status_tracker`

## Requirements
- R1: After reset the status byte, the interrupt line and the read data are all zero.
- R2: The read port returns the status byte when the address equals STATUS_ADDR (default 0x09) and 0x00 for any other address.
- R3: Bit 7 (busy) sets on a frame start or sync break and clears on a frame end, an error or a stop strobe. Frame start and sync break take priority over the clearing events.
- R4: In slave mode, bit 6 (idle timeout) reads 1 once IDLE_CYCLES consecutive cycles have passed with no bus activity, sync break or frame start. Any of these events restarts the count and clears the bit on the next cycle.
- R5: In master mode, bits 6, 5 and 4 read 0, and the stop and identifier strobes set neither the abort flag, the identifier flag nor the interrupt. The stored abort and identifier flags reappear when slave mode returns.
- R6: In slave mode, bit 5 (abort) sets on a sync break that arrives while bit 7 is 1, or on the stop strobe.
- R7: In slave mode, a sync break that arrives while bit 7 is 0 clears bit 5.
- R8: In slave mode, bit 4 (identifier request) sets on an identifier strobe and clears on a sync break. The set wins when both occur together.
- R9: Bit 0 (done) clears on a frame start and sets on a frame end.
- R10: Bit 2 (error) sets on an error event and clears only on the error acknowledge strobe. The set wins when both occur together.
- R11: Bit 3 (interrupt pending) sets on a frame end, an error, a wakeup sent or received, or a slave-mode identifier. It clears only on the interrupt acknowledge strobe, with the set winning over the clear. The interrupt line always equals bit 3.
- R12: Bit 1 (wakeup) sets when a wakeup is sent or received and clears on the next sync break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode_i | input | 1 | 1 selects slave mode, 0 master mode |
| bus_activity_i | input | 1 | Strobe: activity seen on the bus |
| sync_break_i | input | 1 | Strobe: sync break detected |
| id_rcvd_i | input | 1 | Strobe: data identifier received |
| tx_start_i | input | 1 | Strobe: frame started |
| tx_done_i | input | 1 | Strobe: frame finished |
| error_i | input | 1 | Strobe: communication error |
| wake_tx_i | input | 1 | Strobe: wakeup being sent |
| wake_rx_i | input | 1 | Strobe: wakeup received |
| stop_i | input | 1 | Software strobe: stop the frame |
| ack_int_i | input | 1 | Software strobe: clear pending interrupt |
| ack_err_i | input | 1 | Software strobe: clear error flag |
| rd_addr_i | input | ADDR_W | Indirect read address |
| rd_data_o | output | 8 | Indirect read data |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Frames are run in both modes, with single strobes and with set and clear strobes in the same cycle. Single strobes show which bits each event drives. Coincident strobes show that the set has priority. Sync breaks are sent both inside a running frame and between frames, which separates the abort set path from the abort clear path. Idle runs just short of the limit and exactly at it place the timeout edge to the cycle. Toggling the mode shows that the slave-only bits are masked on output but kept in storage.

// File: rtl/lin_status_tracker.sv
module lin_status_tracker #(
  parameter int unsigned IDLE_CYCLES = 200_000_000,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(9)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode_i,
  input  logic              bus_activity_i,
  input  logic              sync_break_i,
  input  logic              id_rcvd_i,
  input  logic              tx_start_i,
  input  logic              tx_done_i,
  input  logic              error_i,
  input  logic              wake_tx_i,
  input  logic              wake_rx_i,
  input  logic              stop_i,
  input  logic              ack_int_i,
  input  logic              ack_err_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [7:0]        status_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1);

  logic busy_q, abort_q, idreq_q, pend_q, err_q, wake_q, done_q;
  logic [CNT_W-1:0] idle_cnt;

  logic bus_seen, idle_full, pend_set, abort_set, abort_clr;

  assign bus_seen  = bus_activity_i | sync_break_i | tx_start_i;
  assign idle_full = (idle_cnt == CNT_W'(IDLE_CYCLES));
  assign pend_set  = tx_done_i | error_i | wake_tx_i | wake_rx_i | (slave_mode_i & id_rcvd_i);
  assign abort_set = slave_mode_i & ((sync_break_i & busy_q) | stop_i);
  assign abort_clr = slave_mode_i & sync_break_i & ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      abort_q  <= 1'b0;
      idreq_q  <= 1'b0;
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
      wake_q   <= 1'b0;
      done_q   <= 1'b0;
      idle_cnt <= '0;
    end else begin
      if (tx_start_i | sync_break_i)          busy_q <= 1'b1;
      else if (tx_done_i | error_i | stop_i)  busy_q <= 1'b0;

      if (abort_set)      abort_q <= 1'b1;
      else if (abort_clr) abort_q <= 1'b0;

      if (slave_mode_i & id_rcvd_i) idreq_q <= 1'b1;
      else if (sync_break_i)        idreq_q <= 1'b0;

      if (pend_set)       pend_q <= 1'b1;
      else if (ack_int_i) pend_q <= 1'b0;

      if (error_i)        err_q <= 1'b1;
      else if (ack_err_i) err_q <= 1'b0;

      if (wake_tx_i | wake_rx_i) wake_q <= 1'b1;
      else if (sync_break_i)     wake_q <= 1'b0;

      if (tx_done_i)       done_q <= 1'b1;
      else if (tx_start_i) done_q <= 1'b0;

      if (bus_seen)        idle_cnt <= '0;
      else if (!idle_full) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign status_o = {busy_q,
                     slave_mode_i & idle_full,
                     slave_mode_i & abort_q,
                     slave_mode_i & idreq_q,
                     pend_q, err_q, wake_q, done_q};
  assign irq_o     = pend_q;
  assign rd_data_o = (rd_addr_i == STATUS_ADDR) ? status_o : 8'h00;
endmodule

module lin_status_tracker_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(9)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_mode_i,
  input logic              bus_activity_i,
  input logic              sync_break_i,
  input logic              id_rcvd_i,
  input logic              tx_start_i,
  input logic              tx_done_i,
  input logic              error_i,
  input logic              wake_tx_i,
  input logic              wake_rx_i,
  input logic              stop_i,
  input logic              ack_int_i,
  input logic              ack_err_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o,
  input logic [7:0]        status_o,
  input logic              irq_o
);
  assert_read_other_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i != STATUS_ADDR) |-> (rd_data_o == 8'h00));
  assert_read_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == STATUS_ADDR) |-> (rd_data_o == status_o));
  assert_busy_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_i |=> status_o[7]);
  assert_activity_clears_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_activity_i |=> !status_o[6]);
  assert_master_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode_i |-> (status_o[6:4] == 3'b000));
  assert_break_clears_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_break_i && !id_rcvd_i) |=> !status_o[4]);
  assert_done_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_i |=> status_o[0]);
  assert_error_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error_i |=> status_o[2]);
  assert_error_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_err_i && !error_i) |=> !status_o[2]);
  assert_irq_tracks_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == status_o[3]);
  assert_wake_sets_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_tx_i || wake_rx_i) |=> status_o[1]);
endmodule

bind lin_status_tracker lin_status_tracker_chk #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_chk (.*);

// File: tb/lin_status_tracker_test.sv
module lin_status_tracker_test;
  localparam int unsigned IDLE = 8;
  localparam int E_ACT = 0, E_BRK = 1, E_ID = 2, E_TS = 3, E_TD = 4, E_ERR = 5,
                 E_WTX = 6, E_WRX = 7, E_STOP = 8, E_RI = 9, E_RE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave = 1'b0;
  logic [10:0] ev = '0;
  logic [7:0] addr = 8'h09;
  logic [7:0] rd_data, status;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { logic [7:0] exp; logic [7:0] msk; string req; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  lin_status_tracker #(.IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .slave_mode_i(slave),
    .bus_activity_i(ev[E_ACT]), .sync_break_i(ev[E_BRK]), .id_rcvd_i(ev[E_ID]),
    .tx_start_i(ev[E_TS]), .tx_done_i(ev[E_TD]), .error_i(ev[E_ERR]),
    .wake_tx_i(ev[E_WTX]), .wake_rx_i(ev[E_WRX]), .stop_i(ev[E_STOP]),
    .ack_int_i(ev[E_RI]), .ack_err_i(ev[E_RE]),
    .rd_addr_i(addr), .rd_data_o(rd_data), .status_o(status), .irq_o(irq));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic [10:0] e, input logic [7:0] exp, input logic [7:0] msk, input string req);
    item_t it;
    @(negedge clk);
    ev = e;
    it.exp = exp; it.msk = msk; it.req = req;
    q.push_back(it);
  endtask

  task automatic quiet();
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.req, status & it.msk, it.exp & it.msk);
        check({it.req, " irq"}, {7'd0, irq}, {7'd0, it.exp[3]});
      end
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 status", status, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 read", rd_data, 8'h00);

    cyc(11'd1 << E_TS, 8'h80, 8'hFF, "R3 start");
    cyc(11'd1 << E_TD, 8'h09, 8'hFF, "R9 done");
    cyc(11'd1 << E_RI, 8'h01, 8'hFF, "R11 ack");
    cyc(11'd1 << E_TS, 8'h80, 8'hFF, "R9 start clears done");
    cyc(11'd1 << E_ERR, 8'h0C, 8'hFF, "R10 error");
    cyc((11'd1 << E_ERR) | (11'd1 << E_RE), 8'h0C, 8'hFF, "R10 set wins");
    cyc(11'd1 << E_RE, 8'h08, 8'hFF, "R10 ack");
    cyc((11'd1 << E_RI) | (11'd1 << E_TD), 8'h09, 8'hFF, "R11 set wins");
    cyc(11'd1 << E_RI, 8'h01, 8'hFF, "R11 ack");
    cyc(11'd1 << E_WRX, 8'h0B, 8'hFF, "R12 wake rx");
    cyc(11'd1 << E_RI, 8'h03, 8'hFF, "R11 ack");
    cyc(11'd1 << E_BRK, 8'h81, 8'hFF, "R12 break clears wake");
    cyc(11'd1 << E_STOP, 8'h01, 8'hFF, "R5 stop in master");
    cyc(11'd1 << E_ID, 8'h01, 8'hFF, "R5 id in master");
    cyc(11'd1 << E_WTX, 8'h0B, 8'hFF, "R12 wake tx");
    cyc(11'd1 << E_RI, 8'h03, 8'hFF, "R11 ack");
    quiet();
    addr = 8'h09;
    #1 check("R2 read match", rd_data, 8'h03);
    addr = 8'h08;
    #1 check("R2 read other", rd_data, 8'h00);
    addr = 8'h09;
    for (int i = 0; i < 10; i++) cyc('0, 8'h03, 8'hFF, "R5 no timeout in master");

    @(negedge clk);
    slave = 1'b1;
    #1 check("R4 saturated timeout", status, 8'h43);
    cyc(11'd1 << E_ACT, 8'h03, 8'hFF, "R4 activity clears");
    for (int i = 1; i < IDLE; i++) cyc('0, 8'h03, 8'hFF, "R4 below limit");
    cyc('0, 8'h43, 8'hFF, "R4 at limit");

    cyc(11'd1 << E_BRK, 8'h81, 8'hBF, "R7 break between frames");
    cyc(11'd1 << E_ID, 8'h99, 8'hBF, "R8 id");
    cyc(11'd1 << E_BRK, 8'hA9, 8'hBF, "R6 break in frame");
    cyc(11'd1 << E_RI, 8'hA1, 8'hBF, "R11 ack");
    cyc(11'd1 << E_TD, 8'h29, 8'hBF, "R9 done slave");
    cyc(11'd1 << E_BRK, 8'h89, 8'hBF, "R7 abort cleared");
    cyc(11'd1 << E_STOP, 8'h29, 8'hBF, "R6 stop");
    cyc((11'd1 << E_ID) | (11'd1 << E_BRK), 8'h99, 8'hBF, "R8 set wins");
    quiet();
    slave = 1'b0;
    #1 check("R5 masked in master", status & 8'hBF, 8'h89);
    @(negedge clk);
    slave = 1'b1;
    #1 check("R5 kept for slave", status & 8'hBF, 8'h99);

    repeat (3) @(negedge clk);
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule